// File: doc/BRIEF.md
# Change-Detect Latched Interrupt Controller

This block watches a vector of real-time status inputs and a set of per-channel transmit sample words. When an unmasked status input toggles in either direction, or when the sample word of an armed channel changes, it raises an active-low interrupt. In the same clock it captures the live status into a status register. From then on the unmasked bits of that register hold their captured values while the masked bits keep following the inputs.

A host clears the interrupt by reading the status register or by writing the mask register. A read returns the captured value in the same cycle and takes effect on the next clock edge. If, at that read, the live unmasked inputs no longer match the captured copy, the interrupt fires again at once and the register takes the fresh values. The interrupt therefore stays low until serviced and must be treated as a level. A mode bit chooses between a driven output and open-drain emulation. In open-drain emulation the output enable is asserted only while the interrupt pulls low.

Top module: `chg_irq_ctrl`

## Requirements
- R1: When a status bit whose mask bit is 0 toggles (rise or fall) while no interrupt is pending, `irq_no` is low from the next clock edge.
- R2: A change of the sample word of channel c (bits c*8+7:c*8 of `tx_samp_i`) raises the interrupt on the next edge when `tx_arm_i[c]` is 1. A change on a channel with arm bit 0 has no effect.
- R3: When the interrupt fires, `rd_data_o` holds the status sampled at that edge. While it is pending, unmasked bits stay frozen and masked bits follow the live inputs one cycle late.
- R4: A cycle with `rd_stat_i` high shows the held status on `rd_data_o` in that cycle and clears the pending interrupt at the following edge.
- R5: If, during that read, a live unmasked status bit differs from the held value, or an armed sample changes, the interrupt stays asserted and `rd_data_o` takes the live status at that edge.
- R6: A mask write loads `mask_wdata_i` into `mask_o` and clears any pending interrupt at the next edge. A mask bit of 1 masks its status bit. The mask write takes priority over a read in the same cycle.
- R7: With `mode_o` = 0 (open drain), `irq_oe_o` is 1 only while `irq_no` is low. With `mode_o` = 1 (driven), `irq_oe_o` is always 1. A mode write does not clear the interrupt.
- R8: While `rst_ni` is low, no interrupt is pending, `mask_o` is all ones, `mode_o` is 0 and `rd_data_o` is zero.
- R9: A status bit whose mask bit is 1 never raises the interrupt, however often it toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stat_i | input | STAT_W | Live status inputs |
| tx_samp_i | input | NUM_CH*SAMP_W | Transmit sample word per channel, channel 0 in the low bits |
| tx_arm_i | input | NUM_CH | Per-channel arm bit for sample-change interrupts |
| rd_stat_i | input | 1 | Status register read strobe |
| rd_data_o | output | STAT_W | Status register contents |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | STAT_W | Mask write data (1 = masked) |
| mask_o | output | STAT_W | Mask register contents |
| mode_wr_i | input | 1 | Output-mode write strobe |
| mode_wdata_i | input | 1 | Output-mode write data (0 open drain, 1 driven) |
| mode_o | output | 1 | Current output mode |
| irq_no | output | 1 | Interrupt, active low |
| irq_oe_o | output | 1 | Interrupt output enable |

## Verification
Directed sequences raise the interrupt with a rising edge and with a falling edge on one unmasked bit. This shows that both directions are detected. Toggling a masked and an unmasked bit while the interrupt is pending separates held bits from tracking bits. A read with the inputs unchanged is contrasted with a read after a new change, which tells a plain clear apart from an immediate re-fire. Sample changes on armed and unarmed channels, a mask write while pending, and both output modes follow. A long random mix of all inputs is then compared every cycle with a behavioural model.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  typedef enum logic {
    DRV_OPEN_DRAIN = 1'b0,
    DRV_PUSH_PULL  = 1'b1
  } drv_mode_e;
endpackage

// File: rtl/chg_irq_edge.sv
module chg_irq_edge #(
  parameter int STAT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] mask_i,
  output logic [STAT_W-1:0] edge_o
);
  logic [STAT_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stat_i;
  end

  assign edge_o = (stat_i ^ prev_q) & ~mask_i;
endmodule

// File: rtl/chg_irq_txwatch.sv
module chg_irq_txwatch #(
  parameter int NUM_CH = 4,
  parameter int SAMP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NUM_CH*SAMP_W-1:0] samp_i,
  input  logic [NUM_CH-1:0]        arm_i,
  output logic                     chg_o
);
  logic [NUM_CH-1:0] hit;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SAMP_W-1:0] prev_q;
    logic [SAMP_W-1:0] cur;
    assign cur = samp_i[c*SAMP_W +: SAMP_W];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= cur;
    end
    assign hit[c] = arm_i[c] && (cur != prev_q);
  end

  assign chg_o = |hit;
endmodule

// File: rtl/chg_irq_drv.sv
module chg_irq_drv
  import chg_irq_pkg::*;
(
  input  drv_mode_e mode_i,
  input  logic      pend_i,
  output logic      irq_no,
  output logic      irq_oe_o
);
  // open drain: only enable the pad while pulling low
  assign irq_no   = ~pend_i;
  assign irq_oe_o = (mode_i == DRV_PUSH_PULL) ? 1'b1 : pend_i;
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int NUM_CH = 4,
  parameter int SAMP_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [STAT_W-1:0]        stat_i,
  input  logic [NUM_CH*SAMP_W-1:0] tx_samp_i,
  input  logic [NUM_CH-1:0]        tx_arm_i,
  input  logic                     rd_stat_i,
  output logic [STAT_W-1:0]        rd_data_o,
  input  logic                     mask_wr_i,
  input  logic [STAT_W-1:0]        mask_wdata_i,
  output logic [STAT_W-1:0]        mask_o,
  input  logic                     mode_wr_i,
  input  logic                     mode_wdata_i,
  output logic                     mode_o,
  output logic                     irq_no,
  output logic                     irq_oe_o
);
  logic              pend_q;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] mask_q;
  drv_mode_e         mode_q;
  logic [STAT_W-1:0] stat_edge;
  logic [STAT_W-1:0] live_diff;
  logic              tx_chg;

  chg_irq_edge #(.STAT_W(STAT_W)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat_i),
    .mask_i (mask_q),
    .edge_o (stat_edge)
  );

  chg_irq_txwatch #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W)) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .samp_i (tx_samp_i),
    .arm_i  (tx_arm_i),
    .chg_o  (tx_chg)
  );

  chg_irq_drv u_drv (
    .mode_i   (mode_q),
    .pend_i   (pend_q),
    .irq_no   (irq_no),
    .irq_oe_o (irq_oe_o)
  );

  // re-compare against the held copy on a read
  assign live_diff = (stat_i ^ stat_q) & ~mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      stat_q <= '0;
      mask_q <= '1;
      mode_q <= DRV_OPEN_DRAIN;
    end else begin
      if (mode_wr_i) mode_q <= drv_mode_e'(mode_wdata_i);
      if (mask_wr_i) begin
        mask_q <= mask_wdata_i;
        pend_q <= 1'b0;
        stat_q <= stat_i;
      end else if (rd_stat_i) begin
        pend_q <= (|live_diff) | tx_chg;
        stat_q <= stat_i;
      end else if (!pend_q) begin
        pend_q <= (|stat_edge) | tx_chg;
        stat_q <= stat_i;
      end else begin
        stat_q <= (stat_q & ~mask_q) | (stat_i & mask_q);
      end
    end
  end

  assign rd_data_o = stat_q;
  assign mask_o    = mask_q;
  assign mode_o    = mode_q;

  a_r1_edge_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pend_q && |stat_edge && !rd_stat_i && !mask_wr_i) |=> !irq_no);

  a_r3_unmasked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !rd_stat_i && !mask_wr_i) |=>
      (!irq_no && ((rd_data_o & ~mask_o) == $past(rd_data_o & ~mask_o))));

  a_r5_read_refire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat_i && !mask_wr_i && |live_diff) |=> (!irq_no && rd_data_o == $past(stat_i)));

  a_r6_mask_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr_i |=> (irq_no && mask_o == $past(mask_wdata_i)));

  a_r7_od_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 1'b0) |-> (irq_oe_o == !irq_no));
endmodule

// File: tb/chg_irq_ctrl_bench.sv
module chg_irq_ctrl_bench;
  localparam int SW = 8;
  localparam int NC = 4;
  localparam int PW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [SW-1:0]   stat_i = '0;
  logic [NC*PW-1:0] tx_samp_i = '0;
  logic [NC-1:0]   tx_arm_i = '0;
  logic            rd_stat_i = 1'b0;
  logic [SW-1:0]   rd_data_o;
  logic            mask_wr_i = 1'b0;
  logic [SW-1:0]   mask_wdata_i = '0;
  logic [SW-1:0]   mask_o;
  logic            mode_wr_i = 1'b0;
  logic            mode_wdata_i = 1'b0;
  logic            mode_o;
  logic            irq_no;
  logic            irq_oe_o;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit          m_pend;
  bit [SW-1:0] m_stat, m_prev, m_mask;
  bit          m_mode;
  int          m_sprev[NC];

  always #5 clk_i = ~clk_i;

  chg_irq_ctrl u_chg_irq_ctrl (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    bit any_tx;
    bit [SW-1:0] edg, dif;
    if (!rst_ni) begin
      m_pend = 0; m_stat = '0; m_prev = '0; m_mask = '1; m_mode = 0;
      foreach (m_sprev[c]) m_sprev[c] = 0;
      return;
    end
    any_tx = 0;
    for (int c = 0; c < NC; c++)
      if (tx_arm_i[c] && int'(tx_samp_i[c*PW +: PW]) != m_sprev[c]) any_tx = 1;
    edg = (stat_i ^ m_prev) & ~m_mask;
    dif = (stat_i ^ m_stat) & ~m_mask;
    if (mode_wr_i) m_mode = mode_wdata_i;
    if (mask_wr_i) begin
      m_mask = mask_wdata_i; m_pend = 0; m_stat = stat_i;
    end else if (rd_stat_i) begin
      m_pend = (dif != 0) || any_tx; m_stat = stat_i;
    end else if (!m_pend) begin
      m_pend = (edg != 0) || any_tx; m_stat = stat_i;
    end else begin
      m_stat = (m_stat & ~m_mask) | (stat_i & m_mask);
    end
    m_prev = stat_i;
    for (int c = 0; c < NC; c++) m_sprev[c] = int'(tx_samp_i[c*PW +: PW]);
  endtask

  task automatic cyc(input string req);
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    chk(req, "irq_no", int'(irq_no), int'(!m_pend));
    chk(req, "rd_data_o", int'(rd_data_o), int'(m_stat));
    chk(req, "mask_o", int'(mask_o), int'(m_mask));
    chk(req, "mode_o", int'(mode_o), int'(m_mode));
    chk("R7", "irq_oe_o", int'(irq_oe_o), int'(m_mode ? 1'b1 : m_pend));
    rd_stat_i = 0; mask_wr_i = 0; mode_wr_i = 0;
  endtask

  task automatic set_samp(input int c, input int v);
    tx_samp_i[c*PW +: PW] = PW'(v);
  endtask

  initial begin
    // R8: reset state
    for (int i = 0; i < 3; i++) cyc("R8");
    chk("R8", "mask all ones", int'(mask_o), 'hff);
    chk("R8", "irq idle", int'(irq_no), 1);
    chk("R8", "open drain oe", int'(irq_oe_o), 0);
    rst_ni = 1;
    cyc("R8");

    // R9: masked toggles do nothing
    stat_i = 8'h0f; cyc("R9");
    stat_i = 8'h00; cyc("R9");
    chk("R9", "masked toggle no irq", int'(irq_no), 1);

    // R6: unmask low nibble
    mask_wr_i = 1; mask_wdata_i = 8'hf0; cyc("R6");
    chk("R6", "mask loaded", int'(mask_o), 'hf0);

    // R1: rising edge
    stat_i = 8'h01; cyc("R1");
    chk("R1", "rise fires", int'(irq_no), 0);
    cyc("R1");
    // R4: read clears
    rd_stat_i = 1; #1 chk("R4", "read data same cycle", int'(rd_data_o), 'h01);
    cyc("R4");
    chk("R4", "cleared", int'(irq_no), 1);
    // R1: falling edge
    stat_i = 8'h00; cyc("R1");
    chk("R1", "fall fires", int'(irq_no), 0);

    // R3: while pending, unmasked held, masked tracks
    stat_i = 8'h22; cyc("R3"); cyc("R3");
    chk("R3", "bit1 held, bit5 tracks", int'(rd_data_o), 'h20);

    // R5: read with differing live input refires with fresh data
    rd_stat_i = 1; cyc("R5");
    chk("R5", "refire", int'(irq_no), 0);
    chk("R5", "fresh data", int'(rd_data_o), 'h22);
    rd_stat_i = 1; cyc("R4");
    chk("R4", "plain clear", int'(irq_no), 1);

    // R2: armed vs unarmed sample change
    tx_arm_i = 4'b0100;
    set_samp(1, 8'h55); cyc("R2"); cyc("R2");
    chk("R2", "unarmed ignored", int'(irq_no), 1);
    set_samp(2, 8'h33); cyc("R2");
    chk("R2", "armed fires", int'(irq_no), 0);
    rd_stat_i = 1; cyc("R2");

    // R7: driven mode, mode write keeps pending
    stat_i = 8'h26; cyc("R7");
    mode_wr_i = 1; mode_wdata_i = 1; cyc("R7");
    chk("R7", "still pending", int'(irq_no), 0);
    chk("R7", "driven oe", int'(irq_oe_o), 1);
    // R6: mask write while pending clears, wins over read
    mask_wr_i = 1; rd_stat_i = 1; mask_wdata_i = 8'h00; cyc("R6");
    chk("R6", "mask write clears", int'(irq_no), 1);
    mode_wr_i = 1; mode_wdata_i = 0; cyc("R7");

    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(3) == 0) stat_i = SW'($urandom);
      if ($urandom_range(5) == 0) tx_samp_i = $urandom;
      if ($urandom_range(7) == 0) tx_arm_i = NC'($urandom);
      rd_stat_i = ($urandom_range(4) == 0);
      if ($urandom_range(30) == 0) begin mask_wr_i = 1; mask_wdata_i = SW'($urandom); end
      if ($urandom_range(40) == 0) begin mode_wr_i = 1; mode_wdata_i = 1'($urandom); end
      cyc("R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule